// File: doc/BRIEF.md
# Attention-Line Packet Sender

This block sends one framed packet over a shared serial line. Before any byte leaves, it claims a separate wired-AND attention line. On a send request it looks at the attention line while its own driver is off. If another node already holds the line low, the request ends at once with a busy result. Otherwise the block pulls the line low and waits two bit periods so that listeners can wake up. It then streams the frame out of a byte buffer, one byte at a time, through an external byte transmitter.

The frame in the buffer starts with the destination address at offset 0 and the payload length at offset 1. The payload follows, and one checksum byte closes the frame. The block computes the byte count from the stored length. The byte transmitter reports each byte with a done strobe and a collision flag. Any collision stops the frame at once. The attention line is let go whenever a frame ends, whatever the outcome. Each outcome is reported with a one-cycle strobe and a 2-bit code, and it also bumps one of three saturating event counters.

Top module: `attn_pkt_sender`

## Requirements
- R1: After reset, `attn_pull`, `tx_start` and `done` are 0 and all three event counters read 0.
- R2: A request seen while idle with `attn_in` low produces `done` with `result` = 1 (busy) in the next cycle. No `tx_start` is issued and `attn_pull` stays 0.
- R3: A request seen while idle with `attn_in` high sets `attn_pull` to 1 in the next cycle. It stays 1 until the cycle in which `done` is high.
- R4: The first `tx_start` of a frame rises exactly 2*BIT_CYCLES+2 cycles after `attn_pull` rises, so the line is held for at least two bit periods before the first byte.
- R5: A frame whose length byte (offset 1) is L sends L+3 bytes. They are taken from buffer offsets 0, 1, 2, … in increasing order, and each `tx_byte` equals the buffer content at its offset.
- R6: When `tx_done` arrives with `tx_coll` high, no further `tx_start` is issued for that frame. In the next cycle `done` is high with `result` = 2 (collision) and `attn_pull` is 0.
- R7: After the `tx_done` of the last byte with `tx_coll` low, the next cycle shows `done` with `result` = 0 (ok), and `attn_pull` returns to 0 in that same cycle.
- R8: `done` is a single-cycle strobe, and `result` never takes the value 3 while `done` is high.
- R9: The counters `cnt_ok`, `cnt_busy` and `cnt_coll` each add one per outcome of their kind and hold at 2^STAT_W-1 instead of wrapping.
- R10: A send request that arrives while a frame is in progress is ignored: it produces no extra `done` and no extra bytes.
- R11: `tx_start` is a single-cycle pulse, and a new `tx_start` never comes before the `tx_done` of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| send_req | input | 1 | Request to send the frame held in the buffer |
| attn_in | input | 1 | Sensed level of the attention line (0 = held low) |
| attn_pull | output | 1 | 1 enables the open-drain pull-down on the attention line |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data, valid one cycle after the address |
| tx_start | output | 1 | One-cycle start strobe to the byte transmitter |
| tx_byte | output | 8 | Byte for the byte transmitter, valid with tx_start |
| tx_done | input | 1 | Byte transmitter finished the current byte |
| tx_coll | input | 1 | Collision flag, qualified by tx_done |
| done | output | 1 | One-cycle strobe marking the end of a request |
| result | output | 2 | Outcome: 0 ok, 1 busy, 2 collision |
| cnt_ok | output | STAT_W | Saturating count of frames sent successfully |
| cnt_busy | output | STAT_W | Saturating count of busy rejections |
| cnt_coll | output | STAT_W | Saturating count of collision aborts |

## Verification
The assertions assume three things about the inputs. `tx_done` comes only while a byte is outstanding and never in the same cycle as `tx_start`. `tx_coll` has meaning only together with `tx_done`. `attn_in` reads low whenever `attn_pull` is high, as a wired line does. The stimulus meets these assumptions in several ways. The bench models the attention line as the AND of the block's pull and a second node's pull. Its byte-transmitter model answers each `tx_start` exactly once, a fixed number of cycles later. It also raises a collision only on the byte index chosen for that frame. The buffer model has the same one-cycle read latency the block expects.

// File: rtl/apx_pkg.sv
package apx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_MEMRD,
    ST_ISSUE,
    ST_WAITTX
  } apx_state_e;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_BUSY = 2'd1,
    RES_COLL = 2'd2
  } apx_res_e;

  // destination address + length byte + checksum byte
  localparam int unsigned APX_FRAME_OVERHEAD = 3;
  localparam int unsigned APX_NUM_RES        = 3;
  localparam int unsigned APX_GAP_BITS       = 2;

endpackage

// File: rtl/apx_gap_timer.sv
module apx_gap_timer #(
  parameter int unsigned GAP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int unsigned CNT_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= CNT_W'(GAP_CYCLES - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);

endmodule

// File: rtl/apx_sat_counter.sv
module apx_sat_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)                  q <= '0;
    else if (inc && q != '1)  q <= q + 1'b1;
  end
endmodule

// File: rtl/apx_frame_seq.sv
module apx_frame_seq
  import apx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic              attn_in,
  input  logic              gap_expired,
  output logic              gap_load,
  output logic              attn_pull,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [DATA_W-1:0] buf_rdata,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  input  logic              tx_done,
  input  logic              tx_coll,
  output logic              done,
  output logic [1:0]        result,
  output logic              active
);
  localparam int unsigned IDX_W = DATA_W + 1;

  apx_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             len_known_q;
  logic [IDX_W-1:0] idx_next;

  assign idx_next = idx_q + 1'b1;
  assign gap_load = (state_q == ST_IDLE) && send_req && attn_in;
  assign active   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      len_known_q <= 1'b0;
      attn_pull   <= 1'b0;
      buf_addr    <= '0;
      tx_start    <= 1'b0;
      tx_byte     <= '0;
      done        <= 1'b0;
      result      <= RES_OK;
    end else begin
      done     <= 1'b0;
      tx_start <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (send_req) begin
            if (!attn_in) begin
              done   <= 1'b1;
              result <= RES_BUSY;
            end else begin
              attn_pull   <= 1'b1;
              idx_q       <= '0;
              len_known_q <= 1'b0;
              state_q     <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_expired) begin
            buf_addr <= '0;
            state_q  <= ST_MEMRD;
          end
        end
        ST_MEMRD: state_q <= ST_ISSUE;
        ST_ISSUE: begin
          tx_start <= 1'b1;
          tx_byte  <= buf_rdata;
          if (idx_q == IDX_W'(1)) begin
            last_q      <= {1'b0, buf_rdata} + IDX_W'(APX_FRAME_OVERHEAD - 1);
            len_known_q <= 1'b1;
          end
          state_q <= ST_WAITTX;
        end
        ST_WAITTX: begin
          if (tx_done) begin
            if (tx_coll) begin
              attn_pull <= 1'b0;
              done      <= 1'b1;
              result    <= RES_COLL;
              state_q   <= ST_IDLE;
            end else if (len_known_q && idx_q == last_q) begin
              attn_pull <= 1'b0;
              done      <= 1'b1;
              result    <= RES_OK;
              state_q   <= ST_IDLE;
            end else begin
              idx_q    <= idx_next;
              buf_addr <= ADDR_W'(idx_next);
              state_q  <= ST_MEMRD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/attn_pkt_sender.sv
module attn_pkt_sender
  import apx_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned BIT_CYCLES = 16,
  parameter int unsigned STAT_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              send_req,
  input  logic              attn_in,
  output logic              attn_pull,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              tx_start,
  output logic [7:0]        tx_byte,
  input  logic              tx_done,
  input  logic              tx_coll,
  output logic              done,
  output logic [1:0]        result,
  output logic [STAT_W-1:0] cnt_ok,
  output logic [STAT_W-1:0] cnt_busy,
  output logic [STAT_W-1:0] cnt_coll
);
  localparam int unsigned GAP_CYCLES = APX_GAP_BITS * BIT_CYCLES;

  logic gap_load;
  logic gap_expired;
  logic seq_active;
  logic [STAT_W-1:0] stat_q [APX_NUM_RES];

  apx_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) gap_i (
    .clk     (clk),
    .rst     (rst),
    .load    (gap_load),
    .expired (gap_expired)
  );

  apx_frame_seq #(.ADDR_W(ADDR_W), .DATA_W(8)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .send_req    (send_req),
    .attn_in     (attn_in),
    .gap_expired (gap_expired),
    .gap_load    (gap_load),
    .attn_pull   (attn_pull),
    .buf_addr    (buf_addr),
    .buf_rdata   (buf_rdata),
    .tx_start    (tx_start),
    .tx_byte     (tx_byte),
    .tx_done     (tx_done),
    .tx_coll     (tx_coll),
    .done        (done),
    .result      (result),
    .active      (seq_active)
  );

  for (genvar k = 0; k < APX_NUM_RES; k++) begin : g_stat
    apx_sat_counter #(.W(STAT_W)) cnt_i (
      .clk (clk),
      .rst (rst),
      .inc (done && (result == 2'(k))),
      .q   (stat_q[k])
    );
  end

  assign cnt_ok   = stat_q[RES_OK];
  assign cnt_busy = stat_q[RES_BUSY];
  assign cnt_coll = stat_q[RES_COLL];

endmodule

// File: rtl/apx_checker.sv
module apx_checker #(
  parameter int unsigned BIT_CYCLES = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       send_req,
  input logic       attn_in,
  input logic       attn_pull,
  input logic       tx_start,
  input logic       tx_done,
  input logic       tx_coll,
  input logic       done,
  input logic [1:0] result,
  input logic       active
);
  localparam int unsigned GAP   = 2 * BIT_CYCLES;
  localparam int unsigned PC_W  = $clog2(GAP + 1) + 1;

  logic [PC_W-1:0] pull_cyc_q;
  logic            outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_cyc_q    <= '0;
      outstanding_q <= 1'b0;
    end else begin
      if (!attn_pull)                  pull_cyc_q <= '0;
      else if (pull_cyc_q < PC_W'(GAP)) pull_cyc_q <= pull_cyc_q + 1'b1;
      if (tx_start)     outstanding_q <= 1'b1;
      else if (tx_done) outstanding_q <= 1'b0;
    end
  end

  assert_busy_reject_R2: assert property (@(posedge clk) disable iff (rst)
    (!active && send_req && !attn_in) |=> (done && result == 2'd1 && !attn_pull));

  assert_claim_R3: assert property (@(posedge clk) disable iff (rst)
    (!active && send_req && attn_in) |=> attn_pull);

  assert_gap_R4: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (attn_pull && pull_cyc_q >= PC_W'(GAP)));

  assert_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (active && tx_done && tx_coll) |=> (done && result == 2'd2 && !attn_pull && !tx_start));

  assert_release_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !attn_pull);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_result_code_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (result != 2'd3));

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !outstanding_q);

endmodule

bind attn_pkt_sender apx_checker #(.BIT_CYCLES(BIT_CYCLES)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .send_req  (send_req),
  .attn_in   (attn_in),
  .attn_pull (attn_pull),
  .tx_start  (tx_start),
  .tx_done   (tx_done),
  .tx_coll   (tx_coll),
  .done      (done),
  .result    (result),
  .active    (seq_active)
);

// File: tb/attn_pkt_sender_tb_top.sv
module attn_pkt_sender_tb_top;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned BIT_CYCLES = 16;
  localparam int unsigned STAT_W     = 3;
  localparam int unsigned TX_LAT     = 5;
  localparam int         SAT_MAX    = (1 << STAT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              send_req = 1'b0;
  logic              other_pull = 1'b0;
  logic              attn_in;
  logic              attn_pull;
  logic [ADDR_W-1:0] buf_addr;
  logic [7:0]        buf_rdata;
  logic              tx_start;
  logic [7:0]        tx_byte;
  logic              tx_done = 1'b0;
  logic              tx_coll = 1'b0;
  logic              done;
  logic [1:0]        result;
  logic [STAT_W-1:0] cnt_ok, cnt_busy, cnt_coll;

  logic [7:0] mem [256];
  int   errors = 0;
  int   checks = 0;
  int   coll_at = -1;
  int   tx_idx = 0;
  int   exp_ok = 0, exp_busy = 0, exp_coll = 0;
  int   done_seen = 0;
  bit   finished = 1'b0;

  logic [7:0] exp_bytes [$];
  logic [1:0] exp_res   [$];

  always #5 clk = ~clk;

  assign attn_in = ~(attn_pull | other_pull);

  always @(posedge clk) buf_rdata <= mem[buf_addr];

  attn_pkt_sender #(.ADDR_W(ADDR_W), .BIT_CYCLES(BIT_CYCLES), .STAT_W(STAT_W)) dut_i (
    .clk(clk), .rst(rst), .send_req(send_req), .attn_in(attn_in), .attn_pull(attn_pull),
    .buf_addr(buf_addr), .buf_rdata(buf_rdata), .tx_start(tx_start), .tx_byte(tx_byte),
    .tx_done(tx_done), .tx_coll(tx_coll), .done(done), .result(result),
    .cnt_ok(cnt_ok), .cnt_busy(cnt_busy), .cnt_coll(cnt_coll)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // byte transmitter model
  initial begin
    forever begin
      @(negedge clk);
      if (tx_start) begin
        repeat (TX_LAT - 1) @(negedge clk);
        tx_done = 1'b1;
        tx_coll = (tx_idx == coll_at);
        @(negedge clk);
        tx_done = 1'b0;
        tx_coll = 1'b0;
        tx_idx++;
      end
    end
  end

  // scoreboard monitor
  initial begin
    bit prev_done = 1'b0, prev_start = 1'b0, outstanding = 1'b0, prev_pull = 1'b0, want_first = 1'b0;
    int gap_cnt = 0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (attn_pull && !prev_pull) begin gap_cnt = 0; want_first = 1'b1; end
        else if (attn_pull) gap_cnt++;
        if (tx_start) begin
          if (want_first) begin
            chk(gap_cnt == 2*BIT_CYCLES + 2, "R4", "first start delay", gap_cnt, 2*BIT_CYCLES + 2);
            want_first = 1'b0;
          end
          chk(!prev_start && !outstanding, "R11", "start pulse/outstanding", int'(outstanding), 0);
          if (exp_bytes.size() == 0) chk(1'b0, "R5", "unexpected byte", int'(tx_byte), -1);
          else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            chk(tx_byte == e, "R5", "byte value", int'(tx_byte), int'(e));
          end
          outstanding = 1'b1;
        end
        if (tx_done) outstanding = 1'b0;
        if (done) begin
          done_seen++;
          chk(!prev_done, "R8", "done width", 1, 0);
          chk(!attn_pull, "R7", "pull released at done", int'(attn_pull), 0);
          if (exp_res.size() == 0) chk(1'b0, "R10", "unexpected done", int'(result), -1);
          else begin
            logic [1:0] r;
            r = exp_res.pop_front();
            chk(result == r, "R8", "result code", int'(result), int'(r));
          end
        end
        prev_done  = done;
        prev_start = tx_start;
        prev_pull  = attn_pull;
      end
    end
  end

  task automatic bump(inout int c);
    if (c < SAT_MAX) c++;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  // frame of length len; collide at byte index ci (-1 for none); optional stray request
  task automatic send_frame(input int len, input int ci, input bit stray);
    int total, last;
    total = len + 3;
    mem[0] = 8'h40 + 8'(len);
    mem[1] = 8'(len);
    for (int i = 2; i < total; i++) mem[i] = 8'((i * 37 + len * 11) & 8'hff);
    last = (ci >= 0) ? ci : total - 1;
    for (int i = 0; i <= last; i++) exp_bytes.push_back(mem[i]);
    exp_res.push_back((ci >= 0) ? 2'd2 : 2'd0);
    coll_at = ci;
    tx_idx = 0;
    @(negedge clk);
    send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
    chk(attn_pull == 1'b1, "R3", "claim after request", int'(attn_pull), 1);
    if (stray) begin
      repeat (40) @(negedge clk);
      chk(attn_pull == 1'b1, "R3", "claim held mid-frame", int'(attn_pull), 1);
      send_req = 1'b1;
      @(negedge clk);
      send_req = 1'b0;
    end
    wait_done();
    chk(attn_pull == 1'b0, (ci >= 0) ? "R6" : "R7", "pull after frame", int'(attn_pull), 0);
    chk(exp_bytes.size() == 0, (ci >= 0) ? "R6" : "R5", "bytes left unsent", exp_bytes.size(), 0);
    if (ci >= 0) bump(exp_coll); else bump(exp_ok);
    repeat (3) @(negedge clk);
  endtask

  task automatic busy_req();
    exp_res.push_back(2'd1);
    other_pull = 1'b1;
    @(negedge clk);
    send_req = 1'b1;
    @(negedge clk);
    send_req = 1'b0;
    chk(done == 1'b1 && result == 2'd1, "R2", "busy result next cycle", int'(result), 1);
    chk(attn_pull == 1'b0, "R2", "no claim when busy", int'(attn_pull), 0);
    repeat (3) @(negedge clk);
    chk(tx_start == 1'b0 && attn_pull == 1'b0, "R2", "idle after busy", int'(tx_start), 0);
    other_pull = 1'b0;
    bump(exp_busy);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(attn_pull == 0 && tx_start == 0 && done == 0, "R1", "outputs after reset", int'(attn_pull), 0);
    chk(cnt_ok == 0 && cnt_busy == 0 && cnt_coll == 0, "R1", "counters after reset", int'(cnt_busy), 0);

    busy_req();
    send_frame(0, -1, 1'b0);          // R5 minimal frame
    send_frame(5, -1, 1'b0);          // R5 R7
    send_frame(4, 3, 1'b0);           // R6 collision mid-frame
    send_frame(2, 0, 1'b0);           // R6 collision on first byte
    send_frame(6, -1, 1'b1);          // R10 stray request ignored
    chk(done_seen == 6, "R10", "done count", done_seen, 6);
    send_frame(1, 3, 1'b0);           // R6 collision on checksum byte
    for (int i = 0; i < 8; i++) busy_req();  // R9 saturation

    chk(int'(cnt_ok) == exp_ok, "R9", "ok counter", int'(cnt_ok), exp_ok);
    chk(int'(cnt_busy) == exp_busy, "R9", "busy counter saturated", int'(cnt_busy), exp_busy);
    chk(int'(cnt_coll) == exp_coll, "R9", "collision counter", int'(cnt_coll), exp_coll);
    chk(exp_res.size() == 0, "R8", "results outstanding", exp_res.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule